// File: doc/BRIEF.md
# Dual-Bandwidth Digital Gain Control Loop with Settle Detection

This block closes a digital gain control loop around an external variable-gain amplifier. Each clock brings one signed 10-bit converter sample. The block takes the magnitude of the sample and subtracts it from a programmable target level. The signed difference is scaled down by an arithmetic right shift and accumulated in a saturating 20-bit integrator. The upper 12 bits of the integrator drive a first-order sigma-delta modulator. Its 1-bit output stream is meant to be smoothed by an external RC filter into the amplifier's control voltage. A polarity input inverts the modulated code, so that amplifiers whose gain falls with rising voltage are also supported.

The loop starts in a wide-bandwidth acquisition mode, which uses a small shift. A settle detector averages the absolute error over fixed 64-sample windows. After four windows in a row whose average lies within a programmable threshold, the lock flag rises and the loop moves to the tracking shift. Downstream acquisition logic is held off until this flag is high. Four bad windows in a row drop the lock and return the loop to acquisition. A restart pulse does the same at once and starts a new window. The integrator is never cleared except by reset, so the loop keeps running when the channel is retuned.

Top module: `agc_loop`

## Requirements
- R1: The error is target minus the magnitude of the two's-complement sample. A sample of -m therefore has the same effect as +m, and -512 counts as magnitude 512.
- R2: A positive error (signal below target) raises gain_level, and a negative error lowers it.
- R3: While unlocked, each sample adds (error >>> acq_shift) to the integrator, rounding toward minus infinity.
- R4: While locked, each sample adds (error >>> trk_shift) to the integrator. bw_trk reads 1 in tracking mode and 0 in acquisition mode.
- R5: The integrator is 20-bit unsigned and resets to 0x80000. It saturates at 0 and at 0xFFFFF and never wraps. gain_level is integrator bits [19:8].
- R6: With slope_inv=0, the modulated output carries a number of ones over any 4096 consecutive cycles that is within 1 of gain_level. A code of 0 gives a constant 0.
- R7: With slope_inv=1, the modulator is driven by 4095 - gain_level.
- R8: Windows are 64 samples long and are counted from reset or restart. A window is good when (sum of |error| over the window) >> 6 is at most lock_thr. Lock rises at the end of the fourth good window in a row, 256 cycles after a restart when the error is constantly zero.
- R9: Lock falls only at the end of the fourth bad window in a row. A shorter run of bad windows leaves lock and tracking mode unchanged.
- R10: A restart pulse clears lock in the next cycle, selects acquisition mode and starts a new window. The integrator value is kept.
- R11: After reset, locked=0, bw_trk=0 and gain_level=0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 10 | Signed converter sample, one per cycle |
| target | input | 10 | Unsigned target magnitude |
| acq_shift | input | 4 | Error shift in acquisition mode |
| trk_shift | input | 4 | Error shift in tracking mode |
| lock_thr | input | 10 | Maximum window-average absolute error for a good window |
| slope_inv | input | 1 | Inverts the modulated control code |
| restart | input | 1 | One-cycle pulse that forces reacquisition |
| gain_sd | output | 1 | Sigma-delta gain control bit stream |
| gain_level | output | 12 | Upper integrator bits, the unmodulated gain code |
| locked | output | 1 | Loop settled; enables downstream acquisition |
| bw_trk | output | 1 | 1 in tracking bandwidth, 0 in acquisition bandwidth |

## Verification
On every cycle, the assertions check four things. The integrator never jumps across its range, which would be a wrap instead of saturation. A zero modulator code never yields a 1. Lock changes only at a window boundary or on a restart. A restart always clears lock in the following cycle. The bench scenarios are needed for the rest: the exact integrator step in each bandwidth, which shows both the shift and the magnitude handling. They also cover the output density against the code with either polarity, and the window counts behind lock entry, hold-through and release.

// File: rtl/agc_pkg.sv
package agc_pkg;
    localparam int SAMPLE_W  = 10;
    localparam int INTEG_W   = 20;
    localparam int CODE_W    = 12;
    localparam int SHIFT_W   = 4;
    localparam int WIN_LOG2  = 6;
    localparam int LOCK_RUNS = 4;
    localparam int ERR_W     = SAMPLE_W + 2;
    localparam int AERR_W    = ERR_W - 1;
    localparam int SUM_W     = AERR_W + WIN_LOG2;
    localparam int RUN_W     = $clog2(LOCK_RUNS + 1);

    typedef enum logic {BW_ACQ = 1'b0, BW_TRK = 1'b1} bw_mode_t;

    typedef struct packed {
        logic signed [ERR_W-1:0] err;
        logic [AERR_W-1:0]       abs_err;
    } agc_err_t;

    function automatic logic [SAMPLE_W-1:0] magnitude(input logic signed [SAMPLE_W-1:0] x);
        return x[SAMPLE_W-1] ? SAMPLE_W'(-x) : x;
    endfunction
endpackage

// File: rtl/agc_error.sv
module agc_error
    import agc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0]        target,
    output agc_err_t                   err_q
);
    logic [SAMPLE_W-1:0]     mag;
    logic signed [ERR_W-1:0] diff;
    logic signed [ERR_W-1:0] diff_abs;

    always_comb begin
        mag      = magnitude(sample);
        diff     = $signed({2'b00, target}) - $signed({2'b00, mag});
        diff_abs = (diff < 0) ? -diff : diff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q.err     <= diff;
            err_q.abs_err <= diff_abs[AERR_W-1:0];
        end
    end
endmodule

// File: rtl/agc_integrator.sv
module agc_integrator
    import agc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  bw_mode_t                mode,
    input  logic [SHIFT_W-1:0]      acq_shift,
    input  logic [SHIFT_W-1:0]      trk_shift,
    input  logic signed [ERR_W-1:0] err,
    output logic [INTEG_W-1:0]      integ_q
);
    localparam logic [INTEG_W-1:0] IMAX = '1;
    localparam logic [INTEG_W-1:0] IMID = INTEG_W'(1) << (INTEG_W - 1);

    logic [SHIFT_W-1:0]        sh;
    logic signed [ERR_W-1:0]   step;
    logic signed [INTEG_W+1:0] sum;
    logic [INTEG_W-1:0]        integ_d;

    always_comb begin
        sh   = (mode == BW_TRK) ? trk_shift : acq_shift;
        step = err >>> sh;
        sum  = $signed({2'b00, integ_q}) + (INTEG_W+2)'(step);
        if (sum < 0)
            integ_d = '0;
        else if (sum > $signed({2'b00, IMAX}))
            integ_d = IMAX;
        else
            integ_d = sum[INTEG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) integ_q <= IMID;
        else     integ_q <= integ_d;
    end

    // R5: saturation, never a wrap across the range
    a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
        ($past(integ_q[INTEG_W-1:INTEG_W-2]) == 2'b11) |-> (integ_q[INTEG_W-1:INTEG_W-2] != 2'b00));
    a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
        ($past(integ_q[INTEG_W-1:INTEG_W-2]) == 2'b00) |-> (integ_q[INTEG_W-1:INTEG_W-2] != 2'b11));
endmodule

// File: rtl/agc_sdm.sv
module agc_sdm
    import agc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              sd_out
);
    logic [CODE_W-1:0] acc_q;
    logic [CODE_W:0]   nxt;

    always_comb nxt = {1'b0, acc_q} + {1'b0, code};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            sd_out <= 1'b0;
        end else begin
            acc_q  <= nxt[CODE_W-1:0];
            sd_out <= nxt[CODE_W];
        end
    end

    // R6: a zero code never emits a one
    a_r6_zero_code: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |=> !sd_out);
endmodule

// File: rtl/agc_lock.sv
module agc_lock
    import agc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic [AERR_W-1:0]   abs_err,
    input  logic [SAMPLE_W-1:0] thr,
    output logic                locked
);
    logic [WIN_LOG2-1:0] cnt_q;
    logic [SUM_W-1:0]    sum_q;
    logic [SUM_W-1:0]    total;
    logic [SUM_W-1:0]    avg;
    logic [RUN_W-1:0]    good_q, bad_q;
    logic                win_end, in_win;

    always_comb begin
        win_end = (cnt_q == '1);
        total   = sum_q + SUM_W'(abs_err);
        avg     = total >> WIN_LOG2;
        in_win  = (avg <= SUM_W'(thr));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q  <= '0;
            sum_q  <= '0;
            good_q <= '0;
            bad_q  <= '0;
            locked <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (win_end) begin
                sum_q <= '0;
                if (in_win) begin
                    bad_q <= '0;
                    if (good_q < RUN_W'(LOCK_RUNS)) good_q <= good_q + 1'b1;
                    if (good_q >= RUN_W'(LOCK_RUNS - 1)) locked <= 1'b1;
                end else begin
                    good_q <= '0;
                    if (bad_q < RUN_W'(LOCK_RUNS)) bad_q <= bad_q + 1'b1;
                    if (bad_q >= RUN_W'(LOCK_RUNS - 1)) locked <= 1'b0;
                end
            end else begin
                sum_q <= total;
            end
        end
    end

    // R8: lock rises only at a window boundary
    a_r8_rise_on_window: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(win_end));
    // R9: lock falls only at a window boundary or on restart
    a_r9_fall_on_window: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(win_end || restart));
endmodule

// File: rtl/agc_loop.sv
module agc_loop
    import agc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [9:0]          sample,
    input  logic [9:0]          target,
    input  logic [3:0]          acq_shift,
    input  logic [3:0]          trk_shift,
    input  logic [9:0]          lock_thr,
    input  logic                slope_inv,
    input  logic                restart,
    output logic                gain_sd,
    output logic [11:0]         gain_level,
    output logic                locked,
    output logic                bw_trk
);
    agc_err_t           err_q;
    bw_mode_t           mode;
    logic [INTEG_W-1:0] integ;
    logic [CODE_W-1:0]  code;

    agc_error u_err (
        .clk(clk), .rst(rst), .sample($signed(sample)), .target(target), .err_q(err_q)
    );

    agc_integrator u_int (
        .clk(clk), .rst(rst), .mode(mode), .acq_shift(acq_shift),
        .trk_shift(trk_shift), .err(err_q.err), .integ_q(integ)
    );

    agc_lock u_lock (
        .clk(clk), .rst(rst), .restart(restart), .abs_err(err_q.abs_err),
        .thr(lock_thr), .locked(locked)
    );

    agc_sdm u_sdm (
        .clk(clk), .rst(rst), .code(code), .sd_out(gain_sd)
    );

    always_comb begin
        mode       = locked ? BW_TRK : BW_ACQ;
        bw_trk     = (mode == BW_TRK);
        gain_level = integ[INTEG_W-1 -: CODE_W];
        code       = slope_inv ? ~gain_level : gain_level;
    end

    // R10: restart forces reacquisition on the next cycle
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> !locked);
endmodule

// File: tb/test_agc_loop.sv
module test_agc_loop;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  sample;
    logic [9:0]  target;
    logic [3:0]  acq_shift, trk_shift;
    logic [9:0]  lock_thr;
    logic        slope_inv, restart;
    logic        gain_sd;
    logic [11:0] gain_level;
    logic        locked, bw_trk;

    int checks = 0;
    int errors = 0;
    int lvl_save;

    localparam int T = 200;

    always #4 clk = ~clk;

    agc_loop i_agc_loop (
        .clk(clk), .rst(rst), .sample(sample), .target(target),
        .acq_shift(acq_shift), .trk_shift(trk_shift), .lock_thr(lock_thr),
        .slope_inv(slope_inv), .restart(restart), .gain_sd(gain_sd),
        .gain_level(gain_level), .locked(locked), .bw_trk(bw_trk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input int s, input int n);
        @(negedge clk);
        sample = 10'(s);
        repeat (n) @(negedge clk);
        sample = 10'(T);
    endtask

    task automatic count_ones(input int n, output int ones);
        ones = 0;
        repeat (n) begin
            @(negedge clk);
            ones += int'(gain_sd);
        end
    endtask

    task automatic t_reset();
        chk(locked == 1'b0, "R11 locked", int'(locked), 0);
        chk(bw_trk == 1'b0, "R11 bw_trk", int'(bw_trk), 0);
        chk(gain_level == 12'h800, "R11 gain_level", int'(gain_level), 2048);
    endtask

    task automatic t_acquire();
        // R3 R1 R2: error 160 >>> 4 = 10 per sample, 128 samples: +1280
        drive(40, 64);
        drive(-40, 64);
        repeat (4) @(negedge clk);
        chk(gain_level == 12'd2053, "R3/R1/R2 acquisition step", int'(gain_level), 2053);
        chk(locked == 1'b0, "R8 no lock with large error", int'(locked), 0);
    endtask

    task automatic t_density(input int exp, input string req);
        int ones;
        repeat (16) @(negedge clk);
        count_ones(4096, ones);
        chk(ones >= exp - 1 && ones <= exp + 1, req, ones, exp);
    endtask

    task automatic t_lock_state(input bit exp, input string req);
        chk(locked == exp, req, int'(locked), int'(exp));
        chk(bw_trk == exp, {req, " bw_trk"}, int'(bw_trk), int'(exp));
    endtask

    task automatic t_track();
        // R4: error 128 >>> 6 = 2 per sample, 128 samples: +256
        drive(T - 128, 128);
        repeat (4) @(negedge clk);
        chk(gain_level == 12'd2054, "R4 tracking step", int'(gain_level), 2054);
        t_lock_state(1'b1, "R9 lock held through short disturbance");
    endtask

    task automatic t_restart();
        lvl_save = int'(gain_level);
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        t_lock_state(1'b0, "R10 restart clears lock");
        chk(int'(gain_level) == lvl_save, "R10 integrator kept", int'(gain_level), lvl_save);
        repeat (249) @(negedge clk);
        chk(locked == 1'b0, "R8 no lock before fourth window", int'(locked), 0);
        repeat (10) @(negedge clk);
        t_lock_state(1'b1, "R8 lock after four good windows");
    endtask

    task automatic t_drop();
        lvl_save = int'(gain_level);
        @(negedge clk);
        sample = 10'(T + 200);
        repeat (150) @(negedge clk);
        chk(locked == 1'b1, "R9 lock held after at most three bad windows", int'(locked), 1);
        repeat (250) @(negedge clk);
        t_lock_state(1'b0, "R9 lock dropped");
        sample = 10'(T);
        repeat (4) @(negedge clk);
        chk(int'(gain_level) < lvl_save, "R2 negative error lowers gain", int'(gain_level), lvl_save - 1);
    endtask

    task automatic t_saturate();
        int ones;
        acq_shift = 4'd0;
        drive(0, 4000);
        repeat (4) @(negedge clk);
        chk(gain_level == 12'hFFF, "R5 saturate high", int'(gain_level), 4095);
        drive(0, 300);
        repeat (4) @(negedge clk);
        chk(gain_level == 12'hFFF, "R5 no wrap at top", int'(gain_level), 4095);
        target = 10'd0;
        sample = 10'h200;
        repeat (5000) @(negedge clk);
        chk(gain_level == 12'h000, "R5 saturate low", int'(gain_level), 0);
        count_ones(256, ones);
        chk(ones == 0, "R6 zero code gives no ones", ones, 0);
        slope_inv = 1'b1;
        t_density(4095, "R7 inverted density at level 0");
        slope_inv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        sample = 10'(T); target = 10'(T);
        acq_shift = 4'd4; trk_shift = 4'd6; lock_thr = 10'd8;
        slope_inv = 1'b0; restart = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_acquire();
        t_density(2053, "R6 density equals code");
        t_lock_state(1'b1, "R8 locked with zero error");
        slope_inv = 1'b1;
        t_density(4095 - 2053, "R7 inverted density");
        slope_inv = 1'b0;
        t_track();
        t_restart();
        t_drop();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule